// File: doc/BRIEF.md
# Reed-Solomon ECC Register Frontend

This block is the register shell that a host uses to drive a Reed-Solomon codec protecting flash memory sectors. It holds the control word, a bank of parity bytes, an interrupt status word and a set of error-report words. It also steps the codec through one code block at a time. Data bytes arrive on a byte stream. They are passed to the codec and counted. When a block ends, the frontend either waits for the codec to produce parity (encode) or waits for the host to load the stored parity and request correction (decode).

The codec itself sits outside the block behind a plain behavioural interface. That interface carries a byte stream, a start pulse, a done pulse, the parity it computed and the error list it found. When an encode result equals the parity of an erased (all-0xFF) sector, the frontend stores all-0xFF parity instead, so erased pages stay erased. Decode results are packed into one word per error: a 1-based symbol index and a correction mask.

The sequencer has six states. IDLE waits for a start. FEED accepts data bytes. CALC waits for the encode result. PARW waits for the host's parity-ready request. CORR waits for the decode result. DONE holds the results. The transitions are:
- IDLE or any other state goes to FEED on a reset pulse while enabled, and to IDLE on a reset pulse while disabled.
- Any state goes to IDLE when enable is low.
- FEED goes to CALC on the last byte in encode mode, and to PARW on the last byte in decode mode.
- CALC goes to DONE on codec done.
- PARW goes to CORR on a parity-ready write.
- CORR goes to DONE on codec done.

Top module: `nfecc_frontend`

## Requirements
- R1: After reset, the control word (offset 0x100), the status word (0x114), all parity words and all error words read 0, and no byte is forwarded to the codec.
- R2: A control write with bit0 (enable) and bit1 (reset) set makes bit1 read 1 for exactly one cycle. In the next cycle it clears the byte count, status and error words, and a new block starts. Setting enable without bit1 does not start a block.
- R3: In a started block, each valid data byte appears on `core_byte` with `core_byte_valid` in the same cycle. Once BLOCK_BYTES bytes have been taken, status bit4 (pad finished) is set and later bytes are not forwarded.
- R4: With control bit3 = 1 (encode), `core_start` pulses for one cycle together with the last byte. On `core_done` the codec parity is stored and status bit2 (encode finished) is set.
- R5: If the encode parity equals the erased-sector pattern (byte0..byte8 = CD 9D 90 58 F4 8B FF B7 6F), all nine stored parity bytes read 0xFF. Any other value is stored as it is.
- R6: Parity byte k is at word 0x108 + 4*(k/4), lane k%4, and is writable per byte lane. `core_par_in` presents the stored bytes. Host parity writes are ignored while the codec is busy (CALC or CORR).
- R7: In decode mode (bit3 = 0), a control write with bit4 set while waiting for parity pulses `core_start` once, and bit4 then reads 1 until the codec finishes. Bit4 written at any other time starts nothing.
- R8: On decode done, status bit3 is set, bit0 shows whether any error was found, and bits 31:29 hold the error count.
- R9: Error word j is at 0x11C + 4*j. For j below the count it holds the symbol index plus one in bits 24:16 and the 9-bit mask in bits 8:0. All other error words read 0.
- R10: A decode error count above MAX_ERR sets status bit1 (uncorrectable) and bit0, leaves the count field 0 and all error words 0.
- R11: A status write clears each strobed flag bit written 0 and keeps each bit written 1, so writing 0 clears every flag.
- R12: After a control write that clears enable, the block goes idle. Later data bytes and codec done pulses change no status bit, parity byte or error word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 9 | Register write byte address |
| reg_wdata | input | 32 | Register write data |
| reg_wstrb | input | 4 | Write byte-lane enables |
| reg_raddr | input | 9 | Register read byte address |
| reg_rdata | output | 32 | Register read data (combinational) |
| din_valid | input | 1 | Data byte valid |
| din_byte | input | 8 | Data byte |
| core_byte_valid | output | 1 | Byte forwarded to codec |
| core_byte | output | 8 | Forwarded byte |
| core_start | output | 1 | Codec start pulse |
| core_encode | output | 1 | Codec mode, 1 = encode |
| core_par_in | output | PAR_BYTES*8 | Stored parity presented to codec |
| core_done | input | 1 | Codec finished |
| core_par_out | input | PAR_BYTES*8 | Parity computed by codec |
| core_err_cnt | input | 3 | Number of errors found |
| core_err_sym | input | MAX_ERR*SYM_W | 0-based symbol index per error |
| core_err_mask | input | MAX_ERR*SYM_W | Correction mask per error |

## Verification
The bench builds the block with BLOCK_BYTES = 16 and keeps nine parity bytes, four error slots and 9-bit symbols at their defaults. The short block lets many full encode and decode blocks run back to back. It also puts the last-byte boundary, the erased-pattern substitution, the count-above-four case and a disable in the middle of a block within a few hundred cycles. Because the register widths stay at their defaults, the byte-lane map and the error-word packing are checked at their real positions.

// File: rtl/nfecc_pkg.sv
package nfecc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FEED,
        S_CALC,
        S_PARW,
        S_CORR,
        S_DONE
    } seq_state_e;

    // register byte offsets (host software depends on these)
    localparam logic [8:0] OFS_CTRL = 9'h100;
    localparam logic [8:0] OFS_PAR  = 9'h108;
    localparam logic [8:0] OFS_STAT = 9'h114;
    localparam logic [8:0] OFS_ERR  = 9'h11C;

    // control bit positions
    localparam int CB_EN   = 0;
    localparam int CB_RST  = 1;
    localparam int CB_RS   = 2;
    localparam int CB_ENC  = 3;
    localparam int CB_PRDY = 4;

    // status flag positions
    localparam int SB_ERR  = 0;
    localparam int SB_UNC  = 1;
    localparam int SB_ENCF = 2;
    localparam int SB_DECF = 3;
    localparam int SB_PADF = 4;

    localparam int CNT_W = 3;

endpackage

// File: rtl/nfecc_seq.sv
module nfecc_seq
    import nfecc_pkg::*;
#(
    parameter int BLOCK_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       encode,
    input  logic       rst_pulse,
    input  logic       par_go,
    input  logic       din_valid,
    input  logic       core_done,
    output seq_state_e state,
    output logic       byte_accept,
    output logic       core_start,
    output logic       pad_done,
    output logic       enc_done,
    output logic       dec_done,
    output logic       busy
);

    localparam int BC_W = $clog2(BLOCK_BYTES + 1);
    localparam logic [BC_W-1:0] LAST_IDX = BC_W'(BLOCK_BYTES - 1);

    seq_state_e      state_q, state_n;
    logic [BC_W-1:0] byte_cnt;
    logic            last_byte;

    assign last_byte = (byte_cnt == LAST_IDX);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // next state and pulse outputs
    always_comb begin
        state_n     = state_q;
        byte_accept = 1'b0;
        core_start  = 1'b0;
        pad_done    = 1'b0;
        enc_done    = 1'b0;
        dec_done    = 1'b0;
        if (rst_pulse) begin
            state_n = en ? S_FEED : S_IDLE;
        end else if (!en) begin
            state_n = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: ;
                S_FEED: begin
                    if (din_valid) begin
                        byte_accept = 1'b1;
                        if (last_byte) begin
                            pad_done = 1'b1;
                            if (encode) begin
                                core_start = 1'b1;
                                state_n    = S_CALC;
                            end else begin
                                state_n    = S_PARW;
                            end
                        end
                    end
                end
                S_CALC: begin
                    if (core_done) begin
                        enc_done = 1'b1;
                        state_n  = S_DONE;
                    end
                end
                S_PARW: begin
                    if (par_go) begin
                        core_start = 1'b1;
                        state_n    = S_CORR;
                    end
                end
                S_CORR: begin
                    if (core_done) begin
                        dec_done = 1'b1;
                        state_n  = S_DONE;
                    end
                end
                S_DONE: ;
                default: state_n = S_IDLE;
            endcase
        end
    end

    // byte counter within the block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           byte_cnt <= '0;
        else if (rst_pulse)   byte_cnt <= '0;
        else if (byte_accept) byte_cnt <= last_byte ? '0 : byte_cnt + 1'b1;
    end

    assign state = state_q;
    assign busy  = (state_q == S_CALC) || (state_q == S_CORR);

endmodule

// File: rtl/nfecc_parity_bank.sv
module nfecc_parity_bank #(
    parameter int                   PAR_BYTES = 9,
    parameter logic [PAR_BYTES*8-1:0] ERASED  = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PAR_BYTES-1:0]   host_we,
    input  logic [PAR_BYTES*8-1:0] host_bytes,
    input  logic                   load,
    input  logic [PAR_BYTES*8-1:0] core_par,
    output logic [PAR_BYTES*8-1:0] par_q
);

    logic is_erased;

    assign is_erased = (core_par == ERASED);

    for (genvar i = 0; i < PAR_BYTES; i++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                par_q[i*8 +: 8] <= 8'h00;
            else if (load)
                par_q[i*8 +: 8] <= is_erased ? 8'hFF : core_par[i*8 +: 8];
            else if (host_we[i])
                par_q[i*8 +: 8] <= host_bytes[i*8 +: 8];
        end
    end

endmodule

// File: rtl/nfecc_err_bank.sv
module nfecc_err_bank #(
    parameter int MAX_ERR = 4,
    parameter int SYM_W   = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     load,
    input  logic [2:0]               cnt,
    input  logic [MAX_ERR*SYM_W-1:0] sym,
    input  logic [MAX_ERR*SYM_W-1:0] mask,
    output logic [MAX_ERR*SYM_W-1:0] idx_q,
    output logic [MAX_ERR*SYM_W-1:0] mask_q
);

    logic fits;

    assign fits = (int'(cnt) <= MAX_ERR);

    for (genvar j = 0; j < MAX_ERR; j++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                idx_q[j*SYM_W +: SYM_W]  <= '0;
                mask_q[j*SYM_W +: SYM_W] <= '0;
            end else if (clear) begin
                idx_q[j*SYM_W +: SYM_W]  <= '0;
                mask_q[j*SYM_W +: SYM_W] <= '0;
            end else if (load) begin
                if (fits && (j < int'(cnt))) begin
                    idx_q[j*SYM_W +: SYM_W]  <= sym[j*SYM_W +: SYM_W] + SYM_W'(1);
                    mask_q[j*SYM_W +: SYM_W] <= mask[j*SYM_W +: SYM_W];
                end else begin
                    idx_q[j*SYM_W +: SYM_W]  <= '0;
                    mask_q[j*SYM_W +: SYM_W] <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/nfecc_frontend.sv
module nfecc_frontend
    import nfecc_pkg::*;
#(
    parameter int                     BLOCK_BYTES = 512,
    parameter int                     PAR_BYTES   = 9,
    parameter int                     MAX_ERR     = 4,
    parameter int                     SYM_W       = 9,
    parameter logic [PAR_BYTES*8-1:0] ERASED      = 72'h6F_B7_FF_8B_F4_58_90_9D_CD
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [8:0]               reg_waddr,
    input  logic [31:0]              reg_wdata,
    input  logic [3:0]               reg_wstrb,
    input  logic [8:0]               reg_raddr,
    output logic [31:0]              reg_rdata,
    input  logic                     din_valid,
    input  logic [7:0]               din_byte,
    output logic                     core_byte_valid,
    output logic [7:0]               core_byte,
    output logic                     core_start,
    output logic                     core_encode,
    output logic [PAR_BYTES*8-1:0]   core_par_in,
    input  logic                     core_done,
    input  logic [PAR_BYTES*8-1:0]   core_par_out,
    input  logic [2:0]               core_err_cnt,
    input  logic [MAX_ERR*SYM_W-1:0] core_err_sym,
    input  logic [MAX_ERR*SYM_W-1:0] core_err_mask
);

    localparam int PAR_W  = PAR_BYTES * 8;
    localparam int NPW    = (PAR_BYTES + 3) / 4;
    localparam int PAD_W  = NPW * 32;

    // control state
    logic        en_q, rs_q, enc_q, rst_pend;
    logic        ctrl_we, stat_we, par_go;
    logic [4:0]  stat_flags, flags_n;
    logic [2:0]  stat_cnt, cnt_n;
    logic        uncor;

    seq_state_e  state;
    logic        byte_accept, pad_done, enc_done, dec_done, busy;

    logic [PAR_BYTES-1:0]     par_we;
    logic [PAR_W-1:0]         par_wbytes;
    logic [PAR_W-1:0]         par_q;
    logic [PAD_W-1:0]         par_pad;
    logic [MAX_ERR*SYM_W-1:0] err_idx, err_mask;

    assign ctrl_we = reg_wr && (reg_waddr == OFS_CTRL) && reg_wstrb[0];
    assign stat_we = reg_wr && (reg_waddr == OFS_STAT);
    assign par_go  = ctrl_we && reg_wdata[CB_PRDY];
    assign uncor   = (int'(core_err_cnt) > MAX_ERR);

    // control register; the reset bit lives for one cycle only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rs_q     <= 1'b0;
            enc_q    <= 1'b0;
            rst_pend <= 1'b0;
        end else if (ctrl_we) begin
            en_q     <= reg_wdata[CB_EN];
            rs_q     <= reg_wdata[CB_RS];
            enc_q    <= reg_wdata[CB_ENC];
            rst_pend <= reg_wdata[CB_RST];
        end else begin
            rst_pend <= 1'b0;
        end
    end

    nfecc_seq #(
        .BLOCK_BYTES(BLOCK_BYTES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .encode     (enc_q),
        .rst_pulse  (rst_pend),
        .par_go     (par_go),
        .din_valid  (din_valid),
        .core_done  (core_done),
        .state      (state),
        .byte_accept(byte_accept),
        .core_start (core_start),
        .pad_done   (pad_done),
        .enc_done   (enc_done),
        .dec_done   (dec_done),
        .busy       (busy)
    );

    // host parity byte writes, mapped by word and lane
    for (genvar i = 0; i < PAR_BYTES; i++) begin : g_pwe
        localparam logic [8:0] WADDR = OFS_PAR + 9'(4 * (i / 4));
        localparam int         LANE  = i % 4;
        assign par_we[i] = reg_wr && !busy && (reg_waddr == WADDR) && reg_wstrb[LANE];
        assign par_wbytes[i*8 +: 8] = reg_wdata[LANE*8 +: 8];
    end

    nfecc_parity_bank #(
        .PAR_BYTES(PAR_BYTES),
        .ERASED   (ERASED)
    ) u_par (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (par_we),
        .host_bytes(par_wbytes),
        .load      (enc_done),
        .core_par  (core_par_out),
        .par_q     (par_q)
    );

    nfecc_err_bank #(
        .MAX_ERR(MAX_ERR),
        .SYM_W  (SYM_W)
    ) u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rst_pend),
        .load  (dec_done),
        .cnt   (core_err_cnt),
        .sym   (core_err_sym),
        .mask  (core_err_mask),
        .idx_q (err_idx),
        .mask_q(err_mask)
    );

    // status: host write-zero-to-clear, then hardware sets win
    always_comb begin
        flags_n = stat_flags;
        cnt_n   = stat_cnt;
        if (stat_we) begin
            if (reg_wstrb[0]) flags_n = flags_n & reg_wdata[4:0];
            if (reg_wstrb[3]) cnt_n   = cnt_n & reg_wdata[31:29];
        end
        if (pad_done) flags_n[SB_PADF] = 1'b1;
        if (enc_done) flags_n[SB_ENCF] = 1'b1;
        if (dec_done) begin
            flags_n[SB_DECF] = 1'b1;
            flags_n[SB_ERR]  = (core_err_cnt != 3'd0);
            flags_n[SB_UNC]  = uncor;
            cnt_n            = uncor ? 3'd0 : core_err_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_flags <= '0;
            stat_cnt   <= '0;
        end else if (rst_pend) begin
            stat_flags <= '0;
            stat_cnt   <= '0;
        end else begin
            stat_flags <= flags_n;
            stat_cnt   <= cnt_n;
        end
    end

    // read mux
    assign par_pad = PAD_W'(par_q);

    always_comb begin
        reg_rdata = '0;
        if (reg_raddr == OFS_CTRL) begin
            reg_rdata[CB_EN]   = en_q;
            reg_rdata[CB_RST]  = rst_pend;
            reg_rdata[CB_RS]   = rs_q;
            reg_rdata[CB_ENC]  = enc_q;
            reg_rdata[CB_PRDY] = (state == S_CORR);
        end
        if (reg_raddr == OFS_STAT) begin
            reg_rdata[4:0]   = stat_flags;
            reg_rdata[31:29] = stat_cnt;
        end
        for (int w = 0; w < NPW; w++) begin
            if (reg_raddr == OFS_PAR + 9'(4 * w))
                reg_rdata = par_pad[w*32 +: 32];
        end
        for (int j = 0; j < MAX_ERR; j++) begin
            if (reg_raddr == OFS_ERR + 9'(4 * j)) begin
                reg_rdata[16 +: SYM_W] = err_idx[j*SYM_W +: SYM_W];
                reg_rdata[0 +: SYM_W]  = err_mask[j*SYM_W +: SYM_W];
            end
        end
    end

    assign core_byte_valid = byte_accept;
    assign core_byte       = din_byte;
    assign core_encode     = enc_q;
    assign core_par_in     = par_q;

endmodule

// File: rtl/nfecc_frontend_chk.sv
module nfecc_frontend_chk #(
    parameter int                 MAX_ERR = 4,
    parameter int                 PAR_W   = 72,
    parameter logic [PAR_W-1:0]   ERASED  = '0
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_pend,
    input logic             ctrl_we,
    input logic [31:0]      reg_wdata,
    input logic             en_q,
    input logic             core_byte_valid,
    input logic             core_start,
    input logic             enc_done,
    input logic             dec_done,
    input logic [2:0]       core_err_cnt,
    input logic [PAR_W-1:0] core_par_out,
    input logic [PAR_W-1:0] par_q,
    input logic [4:0]       stat_flags,
    input logic [2:0]       stat_cnt
);

    // R2: reset bit self-clears unless written again
    a_r2_rst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend && !(ctrl_we && reg_wdata[1]) |=> !rst_pend);

    // R2: reset pulse leaves finish flags and count cleared
    a_r2_rst_clears_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pend |=> (stat_flags[4:2] == 3'b000) && (stat_cnt == 3'd0));

    // R4 / R7: the codec start is a single-cycle pulse
    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start);

    // R5: erased parity pattern is replaced by all ones
    a_r5_erased_sub: assert property (@(posedge clk) disable iff (!rst_n)
        enc_done && (core_par_out == ERASED) |=> (&par_q));

    // R8: decode completion raises its finish flag
    a_r8_dec_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done |=> stat_flags[3]);

    // R10: too many errors marks the block uncorrectable
    a_r10_uncor: assert property (@(posedge clk) disable iff (!rst_n)
        dec_done && (int'(core_err_cnt) > MAX_ERR) |=> stat_flags[1] && stat_flags[0] && (stat_cnt == 3'd0));

    // R10: reported count never exceeds the slot count
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stat_cnt) <= MAX_ERR);

    // R12: while disabled nothing reaches the codec
    a_r12_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q && $past(!en_q) |-> !core_byte_valid && !core_start);

endmodule

bind nfecc_frontend nfecc_frontend_chk #(
    .MAX_ERR(MAX_ERR),
    .PAR_W  (PAR_BYTES * 8),
    .ERASED (ERASED)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rst_pend       (rst_pend),
    .ctrl_we        (ctrl_we),
    .reg_wdata      (reg_wdata),
    .en_q           (en_q),
    .core_byte_valid(core_byte_valid),
    .core_start     (core_start),
    .enc_done       (enc_done),
    .dec_done       (dec_done),
    .core_err_cnt   (core_err_cnt),
    .core_par_out   (core_par_out),
    .par_q          (par_q),
    .stat_flags     (stat_flags),
    .stat_cnt       (stat_cnt)
);

// File: tb/sim_nfecc_frontend.sv
`timescale 1ns/1ps
module sim_nfecc_frontend;

    localparam int BB   = 16;
    localparam int PB   = 9;
    localparam int ME   = 4;
    localparam int SW   = 9;
    localparam logic [71:0] ERASED = 72'h6F_B7_FF_8B_F4_58_90_9D_CD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_wstrb = '0;
    logic [8:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        din_valid = 1'b0;
    logic [7:0]  din_byte = '0;
    logic        core_byte_valid;
    logic [7:0]  core_byte;
    logic        core_start;
    logic        core_encode;
    logic [71:0] core_par_in;
    logic        core_done = 1'b0;
    logic [71:0] core_par_out = '0;
    logic [2:0]  core_err_cnt = '0;
    logic [35:0] core_err_sym = '0;
    logic [35:0] core_err_mask = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    bit start_seen;

    always #2.5 clk = ~clk;

    nfecc_frontend #(
        .BLOCK_BYTES(BB), .PAR_BYTES(PB), .MAX_ERR(ME), .SYM_W(SW), .ERASED(ERASED)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .din_valid(din_valid), .din_byte(din_byte),
        .core_byte_valid(core_byte_valid), .core_byte(core_byte),
        .core_start(core_start), .core_encode(core_encode), .core_par_in(core_par_in),
        .core_done(core_done), .core_par_out(core_par_out), .core_err_cnt(core_err_cnt),
        .core_err_sym(core_err_sym), .core_err_mask(core_err_mask)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] s);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d; reg_wstrb = s;
        #1;
        start_seen = core_start;
        tick();
        reg_wr = 1'b0; reg_wstrb = '0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    // feeds n bytes; returns how many were forwarded intact and whether start was seen
    task automatic feed(input int n, output int fwd, output bit st);
        fwd = 0; st = 0;
        for (int i = 0; i < n; i++) begin
            din_valid = 1'b1;
            din_byte  = 8'($urandom);
            #1;
            if (core_byte_valid && core_byte == din_byte) fwd++;
            if (core_start) st = 1;
            tick();
        end
        din_valid = 1'b0;
    endtask

    task automatic finish_core(input logic [71:0] p, input logic [2:0] c,
                               input logic [35:0] s, input logic [35:0] m);
        core_par_out = p; core_err_cnt = c; core_err_sym = s; core_err_mask = m;
        core_done = 1'b1;
        tick();
        core_done = 1'b0;
    endtask

    task automatic start_blk(input bit enc);
        logic [31:0] v;
        wr(9'h100, enc ? 32'h0F : 32'h07, 4'h1);
        rd(9'h100, v);
        chk("R2 reset bit visible", {31'b0, v[1]}, 32'd1);
        tick();
        rd(9'h100, v);
        chk("R2 reset bit self-cleared", {31'b0, v[1]}, 32'd0);
    endtask

    function automatic logic [31:0] exp_err(input int j, input logic [2:0] c,
                                            input logic [35:0] s, input logic [35:0] m);
        logic [31:0] r = '0;
        if (int'(c) <= ME && j < int'(c)) begin
            r[24:16] = s[j*9 +: 9] + 9'd1;
            r[8:0]   = m[j*9 +: 9];
        end
        return r;
    endfunction

    function automatic logic [31:0] exp_stat_dec(input logic [2:0] c);
        logic [31:0] r = 32'h18;
        if (int'(c) > ME) r[1:0] = 2'b11;
        else begin
            r[0] = (c != 0);
            r[31:29] = c;
        end
        return r;
    endfunction

    function automatic logic [71:0] exp_par(input logic [71:0] p);
        return (p == ERASED) ? {72{1'b1}} : p;
    endfunction

    task automatic chk_par(input string req, input logic [71:0] e);
        logic [31:0] v;
        rd(9'h108, v); chk(req, v, e[31:0]);
        rd(9'h10C, v); chk(req, v, e[63:32]);
        rd(9'h110, v); chk(req, v, {24'b0, e[71:64]});
    endtask

    task automatic run_encode(input logic [71:0] p);
        int fwd; bit st; logic [31:0] v;
        start_blk(1);
        feed(BB, fwd, st);
        chk("R3 bytes forwarded", fwd, BB);
        chk("R4 start with last byte", {31'b0, st}, 32'd1);
        rd(9'h114, v);
        chk("R3 pad finished", v & 32'h1F, 32'h10);
        feed(2, fwd, st);
        chk("R3 extra bytes not forwarded", fwd, 0);
        finish_core(p, '0, '0, '0);
        rd(9'h114, v);
        chk("R4 encode finished", v & 32'h1F, 32'h14);
        chk_par("R4 R5 parity stored", exp_par(p));
    endtask

    task automatic run_decode(input logic [2:0] c, input logic [35:0] s, input logic [35:0] m);
        int fwd; bit st; logic [31:0] v; logic [71:0] p;
        start_blk(0);
        feed(BB, fwd, st);
        chk("R7 no start in decode feed", {31'b0, st}, 32'd0);
        p = {8'($urandom), $urandom, $urandom};
        wr(9'h108, p[31:0], 4'hF);
        wr(9'h10C, p[63:32], 4'hF);
        wr(9'h110, {24'b0, p[71:64]}, 4'h1);
        chk("R6 parity to codec lo", core_par_in[31:0], p[31:0]);
        chk("R6 parity to codec hi", {core_par_in[71:64], core_par_in[63:40]}, {p[71:64], p[63:40]});
        wr(9'h100, 32'h15, 4'h1);
        chk("R7 start on parity ready", {31'b0, start_seen}, 32'd1);
        rd(9'h100, v);
        chk("R7 parity-ready reads 1 while correcting", {31'b0, v[4]}, 32'd1);
        wr(9'h108, ~p[31:0], 4'hF);
        rd(9'h108, v);
        chk("R6 write ignored while busy", v, p[31:0]);
        finish_core('0, c, s, m);
        rd(9'h114, v);
        chk(int'(c) > ME ? "R10 uncorrectable status" : "R8 decode status", v, exp_stat_dec(c));
        for (int j = 0; j < ME; j++) begin
            rd(9'(9'h11C + 4 * j), v);
            chk(int'(c) > ME ? "R10 error word zero" : "R9 error word", v, exp_err(j, c, s, m));
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [71:0] p;
        logic [35:0] s, m;
        int fwd; bit st;
        void'($urandom(32'd24681));
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset values
        rd(9'h100, v); chk("R1 ctrl reset", v, 0);
        rd(9'h114, v); chk("R1 status reset", v, 0);
        chk_par("R1 parity reset", '0);
        rd(9'h11C, v); chk("R1 error reset", v, 0);
        rd(9'h128, v); chk("R1 error reset", v, 0);
        din_valid = 1'b1; #1;
        chk("R1 no forward after reset", {31'b0, core_byte_valid}, 0);
        din_valid = 1'b0;

        // R5 erased and near-erased
        run_encode(ERASED);
        run_encode(ERASED ^ 72'h1);

        // decode corner counts
        run_decode(3'd0, '0, '0);
        s = {9'd300, 9'd7, 9'd0, 9'd510};
        m = {9'h1FF, 9'h001, 9'h0AA, 9'h100};
        run_decode(3'd2, s, m);
        // R11 status write masks
        wr(9'h114, 32'hFFFF_FFF7, 4'hF);
        rd(9'h114, v); chk("R11 clear decode flag only", v, 32'h4000_0011);
        wr(9'h114, 32'h0, 4'hF);
        rd(9'h114, v); chk("R11 write zero clears all", v, 0);
        run_decode(3'd4, s, m);
        run_decode(3'd5, s, m);
        run_decode(3'd7, s, m);

        // R7 parity-ready outside wait state ignored
        start_blk(0);
        feed(5, fwd, st);
        wr(9'h100, 32'h15, 4'h1);
        chk("R7 parity-ready ignored in feed", {31'b0, start_seen}, 0);
        rd(9'h100, v); chk("R7 bit4 reads 0", {31'b0, v[4]}, 0);

        // R12 disable mid-encode freezes results
        p = {8'($urandom), $urandom, $urandom};
        run_encode(p);
        start_blk(1);
        feed(BB, fwd, st);
        wr(9'h100, 32'h0C, 4'h1);
        tick();
        finish_core({8'($urandom), $urandom, $urandom}, '0, '0, '0);
        rd(9'h114, v); chk("R12 no encode flag after disable", v & 32'h1F, 32'h10);
        chk_par("R12 parity frozen", exp_par(p));
        feed(3, fwd, st);
        chk("R12 bytes ignored while disabled", fwd, 0);
        // R2 enable alone does not start
        wr(9'h100, 32'h01, 4'h1);
        tick();
        feed(BB, fwd, st);
        chk("R2 enable without reset no start", fwd, 0);
        rd(9'h114, v); chk("R2 status unchanged", v & 32'h1F, 32'h10);

        // constrained random blocks
        for (int it = 0; it < 12; it++) begin
            if ($urandom_range(0, 1) == 1) begin
                p = ($urandom_range(0, 3) == 0) ? ERASED : {8'($urandom), $urandom, $urandom};
                run_encode(p);
            end else begin
                for (int j = 0; j < ME; j++) begin
                    s[j*9 +: 9] = 9'($urandom_range(0, 500));
                    m[j*9 +: 9] = 9'($urandom);
                end
                run_decode(3'($urandom_range(0, 7)), s, m);
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule